// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This controller brings a serial PHY out of reset after power-up or resume. On a start pulse it turns on the PHY's main PLL clock enable and waits a settle interval. It then asks an external handshake master to select the PHY's internal clock/reset register and write that register's reset bit. After that it polls the lane-0 output status register until the receive PLL reports lock, with a settle interval before each poll.

The handshake master carries out every indirect access. The sequencer only places a request (operation code plus 16-bit data) and holds it until the master accepts it. For acknowledged operations it then waits for a completion strobe, which carries an error flag and read data. The reset write is issued as a fire-and-forget operation, because a PHY in reset cannot acknowledge it.

The sequence ends in one of three ways, each marked by a one-cycle `done` pulse:
- lock seen: `phy_ready` goes high;
- retry budget used up: `lock_timeout` goes high;
- handshake error: `hs_fault` goes high.

Top module: `physeq_ctrl`

## Requirements
- R1: When `start` is sampled high while idle, on the next cycle `busy` and `mpll_en` are high and `phy_ready`, `lock_timeout` and `hs_fault` are low. `mpll_en` then stays high until reset.
- R2: At least `DELAY_CYC` clock cycles pass between a `start` and the first request to the handshake master.
- R3: Once `hs_req` is raised it stays high, with `hs_op` and `hs_wdata` unchanged, until a cycle in which `hs_accept` is high.
- R4: The reset phase issues two requests. The first is an address capture (`hs_op`=0) of 0x7F3F. The second writes 0x0001 with the no-acknowledge write code (`hs_op`=3). The sequencer moves on as soon as that write is accepted, without waiting for `hs_done`.
- R5: Each poll waits at least `DELAY_CYC` cycles, captures address 0x2003 (`hs_op`=0), then issues a read (`hs_op`=2). Lock is bit 1 of `hs_rdata` at `hs_done`; every other bit of the read data is ignored.
- R6: When a read shows lock, `done` pulses once and `phy_ready` rises. `phy_ready` stays high until the next accepted `start` or reset.
- R7: At most `MAX_POLLS` reads are issued per sequence. If the last one shows no lock, `done` pulses with `lock_timeout` high and `phy_ready` low.
- R8: An `hs_done` with `hs_err` high during any acknowledged operation ends the sequence at once: `done` pulses, `hs_fault` goes high, and no further request is made.
- R9: A `start` while `busy` is high has no effect on the running sequence, its requests or its single `done` pulse.
- R10: After reset, `busy`, `done`, `phy_ready`, `lock_timeout`, `hs_fault`, `mpll_en` and `hs_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a reset-and-lock sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| phy_ready | output | 1 | Receive PLL lock confirmed |
| lock_timeout | output | 1 | Retry budget used up without lock |
| hs_fault | output | 1 | Handshake error aborted the sequence |
| mpll_en | output | 1 | PHY main PLL clock enable |
| hs_req | output | 1 | Request to handshake master |
| hs_op | output | 2 | 0 capture address, 1 write, 2 read, 3 write without acknowledge |
| hs_wdata | output | 16 | Address or write data for the request |
| hs_accept | input | 1 | Master takes the request this cycle |
| hs_done | input | 1 | Acknowledged operation completed |
| hs_err | input | 1 | Completion ended in a handshake timeout |
| hs_rdata | input | 16 | Read data, valid with `hs_done` |

## Verification
The hardest situations to reach are the edges of the retry budget: lock on exactly the last permitted read, and no lock at all. The bench's handshake-master model holds a lock threshold expressed as a read index, so a run can be steered to lock on the tenth read, or never. The model can also inject an error on any chosen operation index, and it can stretch its accept latency, which keeps requests pending for several cycles. It never answers the no-acknowledge write, so a sequencer that waited for that completion would hang in the bench.

// File: rtl/physeq_pkg.sv
package physeq_pkg;

  typedef enum logic [1:0] {
    OP_CAP_ADDR    = 2'd0,
    OP_WRITE       = 2'd1,
    OP_READ        = 2'd2,
    OP_WRITE_NOACK = 2'd3
  } hs_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CLK_WAIT,
    S_RST_ADDR,
    S_RST_ADDR_WT,
    S_RST_WR,
    S_POLL_DLY,
    S_POLL_ADDR,
    S_POLL_ADDR_WT,
    S_POLL_RD,
    S_POLL_RD_WT
  } seq_state_e;

  localparam logic [15:0] CLKRST_ADDR    = 16'h7F3F;
  localparam logic [15:0] RST_VALUE      = 16'h0001;
  localparam logic [15:0] LANE_STAT_ADDR = 16'h2003;
  localparam int          LOCK_BIT       = 1;

endpackage

// File: rtl/physeq_rst_sync.sv
module physeq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/physeq_delay.sv
module physeq_delay #(
  parameter int DELAY_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? LOAD_VAL : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  AST_TMR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expired); // R2
  AST_TMR_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired); // R2
endmodule

// File: rtl/physeq_poll_cnt.sv
module physeq_poll_cnt #(
  parameter int MAX_POLLS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [PW-1:0] LAST_VAL = PW'(MAX_POLLS - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || inc;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == LAST_VAL);

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_VAL); // R7
  AST_NO_INC_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last && !clr |-> !inc); // R7
endmodule

// File: rtl/physeq_ctrl.sv
module physeq_ctrl
  import physeq_pkg::*;
#(
  parameter int DELAY_CYC = 15000,
  parameter int MAX_POLLS = 10,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          phy_ready,
  output logic          lock_timeout,
  output logic          hs_fault,
  output logic          mpll_en,
  output logic          hs_req,
  output logic [1:0]    hs_op,
  output logic [DW-1:0] hs_wdata,
  input  logic          hs_accept,
  input  logic          hs_done,
  input  logic          hs_err,
  input  logic [DW-1:0] hs_rdata
);
  logic rst_sync_n;

  seq_state_e st_q, st_d;
  logic tmr_load, tmr_expired;
  logic cnt_clr, cnt_inc, poll_last;
  logic fin_ok, fin_tmo, fin_err, start_acc;
  logic done_q, ready_q, tmo_q, fault_q, mpll_q;
  hs_op_e op_c;
  logic [DW-1:0] wdata_c;
  logic in_wait;

  physeq_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_sync_n)
  );

  physeq_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (tmr_load),
    .expired(tmr_expired)
  );

  physeq_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (cnt_clr),
    .inc  (cnt_inc),
    .last (poll_last)
  );

  // next-state logic
  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    fin_ok    = 1'b0;
    fin_tmo   = 1'b0;
    fin_err   = 1'b0;
    start_acc = 1'b0;
    unique case (st_q)
      S_IDLE: if (start) begin
        start_acc = 1'b1;
        tmr_load  = 1'b1;
        cnt_clr   = 1'b1;
        st_d      = S_CLK_WAIT;
      end
      S_CLK_WAIT: if (tmr_expired) st_d = S_RST_ADDR;
      S_RST_ADDR: if (hs_accept) st_d = S_RST_ADDR_WT;
      S_RST_ADDR_WT: if (hs_done) begin
        if (hs_err) begin
          fin_err = 1'b1;
          st_d    = S_IDLE;
        end else begin
          st_d = S_RST_WR;
        end
      end
      S_RST_WR: if (hs_accept) begin
        tmr_load = 1'b1;
        st_d     = S_POLL_DLY;
      end
      S_POLL_DLY: if (tmr_expired) st_d = S_POLL_ADDR;
      S_POLL_ADDR: if (hs_accept) st_d = S_POLL_ADDR_WT;
      S_POLL_ADDR_WT: if (hs_done) begin
        if (hs_err) begin
          fin_err = 1'b1;
          st_d    = S_IDLE;
        end else begin
          st_d = S_POLL_RD;
        end
      end
      S_POLL_RD: if (hs_accept) st_d = S_POLL_RD_WT;
      S_POLL_RD_WT: if (hs_done) begin
        if (hs_err) begin
          fin_err = 1'b1;
          st_d    = S_IDLE;
        end else if (hs_rdata[LOCK_BIT]) begin
          fin_ok = 1'b1;
          st_d   = S_IDLE;
        end else if (poll_last) begin
          fin_tmo = 1'b1;
          st_d    = S_IDLE;
        end else begin
          cnt_inc  = 1'b1;
          tmr_load = 1'b1;
          st_d     = S_POLL_DLY;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  // request decode
  always_comb begin
    hs_req  = 1'b0;
    op_c    = OP_CAP_ADDR;
    wdata_c = '0;
    unique case (st_q)
      S_RST_ADDR: begin
        hs_req  = 1'b1;
        wdata_c = DW'(CLKRST_ADDR);
      end
      S_RST_WR: begin
        hs_req  = 1'b1;
        op_c    = OP_WRITE_NOACK;
        wdata_c = DW'(RST_VALUE);
      end
      S_POLL_ADDR: begin
        hs_req  = 1'b1;
        wdata_c = DW'(LANE_STAT_ADDR);
      end
      S_POLL_RD: begin
        hs_req = 1'b1;
        op_c   = OP_READ;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= S_IDLE;
      done_q  <= 1'b0;
      ready_q <= 1'b0;
      tmo_q   <= 1'b0;
      fault_q <= 1'b0;
      mpll_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_ok || fin_tmo || fin_err;
      if (start_acc || fin_ok)  ready_q <= fin_ok;
      if (start_acc || fin_tmo) tmo_q   <= fin_tmo;
      if (start_acc || fin_err) fault_q <= fin_err;
      if (start_acc)            mpll_q  <= 1'b1;
    end
  end

  assign busy         = (st_q != S_IDLE);
  assign done         = done_q;
  assign phy_ready    = ready_q;
  assign lock_timeout = tmo_q;
  assign hs_fault     = fault_q;
  assign mpll_en      = mpll_q;
  assign hs_op        = op_c;
  assign hs_wdata     = wdata_c;
  assign in_wait      = (st_q == S_RST_ADDR_WT) || (st_q == S_POLL_ADDR_WT) ||
                        (st_q == S_POLL_RD_WT);

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && !busy) |=> (busy && mpll_en && !phy_ready && !hs_fault && !lock_timeout)); // R1
  AST_MPLL_KEEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mpll_en |=> mpll_en); // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hs_req && !hs_accept) |=> (hs_req && $stable(hs_op) && $stable(hs_wdata))); // R3
  AST_REQ_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hs_req |-> mpll_en); // R2
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phy_ready && !start) |=> phy_ready); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> ($countones({phy_ready, lock_timeout, hs_fault}) == 1)); // R7
  AST_ABORT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_wait && hs_done && hs_err) |=> (!busy && done && hs_fault)); // R8
endmodule

// File: tb/physeq_ctrl_test.sv
module physeq_ctrl_test;
  localparam int DLY  = 20;
  localparam int MAXP = 10;

  logic clk, rst_n, start;
  logic busy, done, phy_ready, lock_timeout, hs_fault, mpll_en, hs_req;
  logic [1:0] hs_op;
  logic [15:0] hs_wdata, hs_rdata;
  logic hs_accept, hs_done, hs_err;

  physeq_ctrl #(.DELAY_CYC(DLY), .MAX_POLLS(MAXP), .DW(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .phy_ready(phy_ready), .lock_timeout(lock_timeout), .hs_fault(hs_fault),
    .mpll_en(mpll_en), .hs_req(hs_req), .hs_op(hs_op), .hs_wdata(hs_wdata),
    .hs_accept(hs_accept), .hs_done(hs_done), .hs_err(hs_err), .hs_rdata(hs_rdata)
  );

  int checks = 0, failures = 0;
  int cyc = 0, done_cnt = 0;
  int acc_lat = 0, err_at = -1, lock_after = 1;
  logic [15:0] nolock_val = 16'h0000;
  int ops = 0, reads = 0, first_req = -1, start_cyc = 0;
  logic [1:0]  op_log [64];
  logic [15:0] dat_log [64];
  logic [15:0] cur_addr = 16'h0;
  bit finished = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(negedge clk);
    if (done) done_cnt++;
  end

  // handshake master model
  initial begin
    hs_accept = 1'b0; hs_done = 1'b0; hs_err = 1'b0; hs_rdata = 16'h0;
    forever begin
      @(negedge clk);
      if (hs_req) begin
        if (first_req < 0) first_req = cyc;
        repeat (acc_lat) @(negedge clk);
        begin
          automatic int idx = ops;
          automatic logic [1:0] op = hs_op;
          hs_accept = 1'b1;
          if (ops < 64) begin
            op_log[ops]  = hs_op;
            dat_log[ops] = hs_wdata;
          end
          ops++;
          if (op == 2'd0) cur_addr = hs_wdata;
          @(negedge clk);
          hs_accept = 1'b0;
          if (op != 2'd3) begin
            @(negedge clk);
            hs_done = 1'b1;
            hs_err  = (idx == err_at);
            if (op == 2'd2) begin
              reads++;
              hs_rdata = (cur_addr == 16'h2003 && reads >= lock_after) ? 16'h0002 : nolock_val;
            end
            @(negedge clk);
            hs_done = 1'b0; hs_err = 1'b0; hs_rdata = 16'h0;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input int lat, input int errat, input int lockat, input logic [15:0] nl);
    acc_lat = lat; err_at = errat; lock_after = lockat; nolock_val = nl;
    ops = 0; reads = 0; first_req = -1; done_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !phy_ready && !lock_timeout && !hs_fault && !mpll_en && !hs_req,
        "R10 reset outputs", {busy, phy_ready, mpll_en, hs_req}, 0);
  endtask

  task automatic t_lock_third();
    setup(0, -1, 3, 16'h0000);
    pulse_start();
    chk(busy && mpll_en && !phy_ready, "R1 start taken", {busy, mpll_en, phy_ready}, 6);
    wait_done();
    chk(first_req - start_cyc >= DLY, "R2 settle before first request", first_req - start_cyc, DLY);
    chk(op_log[0] == 2'd0 && dat_log[0] == 16'h7F3F, "R4 reset address capture", dat_log[0], 16'h7F3F);
    chk(op_log[1] == 2'd3 && dat_log[1] == 16'h0001, "R4 no-ack reset write", dat_log[1], 1);
    chk(op_log[2] == 2'd0 && dat_log[2] == 16'h2003 && op_log[3] == 2'd2, "R5 poll address and read",
        dat_log[2], 16'h2003);
    chk(ops == 8 && reads == 3, "R5 three polls", reads, 3);
    chk(phy_ready && !lock_timeout && !hs_fault && done_cnt == 1, "R6 lock reported", phy_ready, 1);
    repeat (30) @(negedge clk);
    chk(phy_ready && mpll_en, "R6 phy_ready held", phy_ready, 1);
  endtask

  task automatic t_slow_accept();
    setup(4, -1, 2, 16'hFFFD);
    pulse_start();
    chk(!phy_ready, "R1 new start clears phy_ready", phy_ready, 0);
    wait_done();
    chk(ops == 6, "R3 one accept per held request", ops, 6);
    chk(reads == 2 && phy_ready, "R5 non-lock bits ignored", reads, 2);
  endtask

  task automatic t_no_lock();
    setup(0, -1, 99, 16'h0000);
    pulse_start();
    wait_done();
    chk(reads == MAXP, "R7 read budget", reads, MAXP);
    chk(lock_timeout && !phy_ready && !hs_fault && done_cnt == 1, "R7 timeout flag", lock_timeout, 1);
  endtask

  task automatic t_lock_last();
    setup(0, -1, MAXP, 16'h0000);
    pulse_start();
    wait_done();
    chk(reads == MAXP && phy_ready && !lock_timeout, "R7 lock on last read", reads, MAXP);
  endtask

  task automatic t_err_rst_addr();
    setup(0, 0, 1, 16'h0000);
    pulse_start();
    wait_done();
    chk(hs_fault && !phy_ready && done_cnt == 1, "R8 fault on reset capture", hs_fault, 1);
    repeat (100) @(negedge clk);
    chk(ops == 1 && !busy, "R8 no request after abort", ops, 1);
  endtask

  task automatic t_err_read();
    setup(0, 3, 1, 16'h0000);
    pulse_start();
    wait_done();
    repeat (60) @(negedge clk);
    chk(ops == 4 && reads == 1 && hs_fault && !phy_ready, "R8 fault on poll read", ops, 4);
  endtask

  task automatic t_busy_start();
    setup(0, -1, 2, 16'h0000);
    pulse_start();
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (60) @(negedge clk);
    chk(ops == 6 && done_cnt == 1 && phy_ready, "R9 start while busy ignored", ops, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    start = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lock_third();
    t_slow_accept();
    t_no_lock();
    t_lock_last();
    t_err_rst_addr();
    t_err_read();
    t_busy_start();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule